// File: doc/BRIEF.md
# Buffered Sample Streamer for a Parallel Peripheral Bus

This block sits on an 8-bit parallel backplane as a write-mostly peripheral. A host stores waveform samples by writing bytes to it. The bytes land in an internal first-in first-out buffer. A free-running pacing divider, clocked from the system clock, removes one word per tick. Each removed word is presented to a DAC data port and then latched there with a one-cycle load strobe. The host can check the buffer level by reading a status byte. The status byte carries the empty, half-full and full flags.

The bus side uses an active-high master reset and three active-low strobes: module select, read and write. An address match against a parameterised mask and value qualifies all three. With the default mask every address is accepted. Each buffer word is nine bits wide. The upper bit is written as 0 from the bus and appears on a channel-select output beside the DAC data. The analog conversion and any filtering lie outside this block.

Top module: `sample_streamer`

## Requirements
- R1: A write strobe starts when select and write are both low together. Each such strobe stores the data bus value exactly once. A write low while select is high stores nothing.
- R2: The block drives the data bus only while select and read are both low. At all other times it releases the bus.
- R3: The status byte has these fields: bit 0 is 1 when the buffer is empty, bit 2 is 1 when it holds at least DEPTH/2 words, bit 3 is 1 when it holds DEPTH words, and bits 1 and 7..4 always read 0.
- R4: A write while the buffer holds DEPTH words is discarded. The stored contents stay unchanged.
- R5: Words leave in the order they were written, and up to DEPTH words can be held.
- R6: A pacing tick occurs every DIV system clocks. A tick with a non-empty buffer removes one word. That word appears on the DAC data and channel outputs in the following cycle. The load strobe is high for exactly one cycle, one cycle after the data changed.
- R7: A tick while the buffer is empty removes nothing and raises no load strobe.
- R8: Master reset empties the buffer, sets the status to 0x01 and clears the DAC outputs and the divider.
- R9: Every word written from the bus leaves with channel select 0.
- R10: The status byte is captured when a read strobe begins. It stays constant on the bus for the whole strobe, even if the buffer level changes meanwhile.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Master reset, active high |
| bus_addr | input | 8 | Address bus |
| bus_data | inout | 8 | Bidirectional data bus |
| sel_n | input | 1 | Module select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| dac_data | output | 8 | Sample value to the DAC |
| dac_chan | output | 1 | Channel select for the DAC |
| dac_load | output | 1 | One-cycle DAC latch strobe |

## Verification
A bad occupancy count shows up at the ports in two ways. The next status read carries the wrong flag pattern. Or, within DIV cycles of the first affected tick, the DAC emits a word too many or too few. Pointer faults show up as reordered or repeated words in the DAC stream. Strobe-timing faults show up as wrong gaps between load pulses, or as a load arriving in the same cycle as its data. A dropped or doubled push changes the total count of loads seen after a drain.

// File: rtl/ss_pkg.sv
package ss_pkg;
   localparam int BUS_W = 8;

   // status byte field positions
   localparam int STAT_EMPTY = 0;
   localparam int STAT_HALF  = 2;
   localparam int STAT_FULL  = 3;

   typedef struct packed {
      logic             chan;
      logic [BUS_W-1:0] data;
   } sample_t;

   localparam int WORD_W = $bits(sample_t);
endpackage

// File: rtl/ss_fifo.sv
module ss_fifo #(
   parameter int DEPTH = 256,
   localparam int PW = $clog2(DEPTH),
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            push,
   input  ss_pkg::sample_t wword,
   input  logic            pop,
   output ss_pkg::sample_t rword,
   output logic [CW-1:0]   level,
   output logic            empty,
   output logic            half,
   output logic            full
);
   if (DEPTH < 4) begin : g_bad_depth
      $error("ss_fifo: DEPTH must be at least 4");
   end

   ss_pkg::sample_t mem [DEPTH];
   logic [PW-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic push_ok, pop_ok;

   assign empty = (level == '0);
   assign full  = (level == CW'(DEPTH));
   assign half  = (level >= CW'(DEPTH / 2));

   assign push_ok = push & ~full;
   assign pop_ok  = pop & ~empty;

   if ((1 << PW) == DEPTH) begin : g_pow2
      assign wr_nxt = wr_ptr + 1'b1;
      assign rd_nxt = rd_ptr + 1'b1;
   end else begin : g_wrap
      assign wr_nxt = (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      assign rd_nxt = (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (push_ok) mem[wr_ptr] <= wword;
   end

   assign rword = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (rst) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else begin
         if (push_ok) wr_ptr <= wr_nxt;
         if (pop_ok)  rd_ptr <= rd_nxt;
         case ({push_ok, pop_ok})
            2'b10:   level <= level + 1'b1;
            2'b01:   level <= level - 1'b1;
            default: level <= level;
         endcase
      end
   end
endmodule

// File: rtl/ss_bus_port.sv
module ss_bus_port #(
   parameter logic [7:0] ADDR_MATCH = 8'h00,
   parameter logic [7:0] ADDR_CARE  = 8'h00
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic [7:0]               bus_addr,
   input  logic                     sel_n,
   input  logic                     rd_n,
   input  logic                     wr_n,
   input  logic [ss_pkg::BUS_W-1:0] din,
   input  logic                     flag_empty,
   input  logic                     flag_half,
   input  logic                     flag_full,
   output logic                     push_req,
   output ss_pkg::sample_t          push_word,
   output logic                     drv_en,
   output logic [ss_pkg::BUS_W-1:0] dout
);
   import ss_pkg::*;

   if (BUS_W <= STAT_FULL) begin : g_bad_width
      $error("ss_bus_port: bus too narrow for the status byte");
   end

   logic addr_hit, wr_act, rd_act, wr_q;
   logic [BUS_W-1:0] live_stat, stat_hold;

   assign addr_hit = (((bus_addr ^ ADDR_MATCH) & ADDR_CARE) == 8'h00);
   assign wr_act   = addr_hit & ~sel_n & ~wr_n;
   assign rd_act   = addr_hit & ~sel_n & ~rd_n;

   always_ff @(posedge clk) begin
      if (rst) wr_q <= 1'b0;
      else     wr_q <= wr_act;
   end

   assign push_req       = wr_act & ~wr_q;
   assign push_word.chan = 1'b0;
   assign push_word.data = din;

   always_comb begin
      live_stat             = '0;
      live_stat[STAT_EMPTY] = flag_empty;
      live_stat[STAT_HALF]  = flag_half;
      live_stat[STAT_FULL]  = flag_full;
   end

   // tracks the flags while idle, frozen from the first cycle of a read
   always_ff @(posedge clk) begin
      if (rst) begin
         stat_hold             <= '0;
         stat_hold[STAT_EMPTY] <= 1'b1;
      end else if (!rd_act) begin
         stat_hold <= live_stat;
      end
   end

   assign drv_en = rd_act;
   assign dout   = stat_hold;
endmodule

// File: rtl/ss_pacer.sv
module ss_pacer #(
   parameter int DIV = 256,
   localparam int DVW = (DIV > 2) ? $clog2(DIV) : 1
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     empty,
   input  ss_pkg::sample_t          head,
   output logic                     pop,
   output logic [ss_pkg::BUS_W-1:0] dac_data,
   output logic                     dac_chan,
   output logic                     dac_load
);
   if (DIV < 2) begin : g_bad_div
      $error("ss_pacer: DIV must be at least 2");
   end

   logic [DVW-1:0] cnt;
   logic tick, load_pend;

   if ((1 << DVW) == DIV) begin : g_pow2
      always_ff @(posedge clk) begin
         if (rst) cnt <= '0;
         else     cnt <= cnt + 1'b1;
      end
      assign tick = &cnt;
   end else begin : g_cmp
      always_ff @(posedge clk) begin
         if (rst)                        cnt <= '0;
         else if (cnt == DVW'(DIV - 1))  cnt <= '0;
         else                            cnt <= cnt + 1'b1;
      end
      assign tick = (cnt == DVW'(DIV - 1));
   end

   assign pop = tick & ~empty;

   always_ff @(posedge clk) begin
      if (rst) begin
         dac_data  <= '0;
         dac_chan  <= 1'b0;
         load_pend <= 1'b0;
         dac_load  <= 1'b0;
      end else begin
         if (pop) begin
            dac_data <= head.data;
            dac_chan <= head.chan;
         end
         load_pend <= pop;
         dac_load  <= load_pend;
      end
   end
endmodule

// File: rtl/sample_streamer.sv
module sample_streamer #(
   parameter int         DEPTH      = 256,
   parameter int         DIV        = 256,
   parameter logic [7:0] ADDR_MATCH = 8'h00,
   parameter logic [7:0] ADDR_CARE  = 8'h00,
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic       clk,
   input  logic       rst,
   input  logic [7:0] bus_addr,
   inout  wire  [7:0] bus_data,
   input  logic       sel_n,
   input  logic       rd_n,
   input  logic       wr_n,
   output logic [7:0] dac_data,
   output logic       dac_chan,
   output logic       dac_load
);
   ss_pkg::sample_t push_word, head;
   logic push_req, pop, drv_en, empty, half, full;
   logic [CW-1:0] level;
   logic [7:0] dout;

   ss_bus_port #(.ADDR_MATCH(ADDR_MATCH), .ADDR_CARE(ADDR_CARE)) u_port (
      .clk(clk), .rst(rst), .bus_addr(bus_addr),
      .sel_n(sel_n), .rd_n(rd_n), .wr_n(wr_n), .din(bus_data),
      .flag_empty(empty), .flag_half(half), .flag_full(full),
      .push_req(push_req), .push_word(push_word),
      .drv_en(drv_en), .dout(dout)
   );

   ss_fifo #(.DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst(rst), .push(push_req), .wword(push_word),
      .pop(pop), .rword(head), .level(level),
      .empty(empty), .half(half), .full(full)
   );

   ss_pacer #(.DIV(DIV)) u_pacer (
      .clk(clk), .rst(rst), .empty(empty), .head(head), .pop(pop),
      .dac_data(dac_data), .dac_chan(dac_chan), .dac_load(dac_load)
   );

   assign bus_data = drv_en ? dout : 8'hzz;
endmodule

// File: rtl/sample_streamer_chk.sv
module sample_streamer_chk #(
   parameter int DEPTH = 256,
   parameter int CW    = 9
) (
   input logic          clk,
   input logic          rst,
   input logic [CW-1:0] level,
   input logic          full,
   input logic          empty,
   input logic          push_req,
   input logic          pop,
   input logic          drv_en,
   input logic [7:0]    dout,
   input logic [7:0]    dac_data,
   input logic          dac_load
);
   // R5: occupancy never exceeds the depth
   a_r5_no_overflow: assert property (@(posedge clk) disable iff (rst)
      level <= CW'(DEPTH));

   // R4: a push into a full buffer without a pop leaves the level unchanged
   a_r4_full_discard: assert property (@(posedge clk) disable iff (rst)
      (full && push_req && !pop) |=> (level == CW'(DEPTH)));

   // R3: full and empty never coexist
   a_r3_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
      !(full && empty));

   // R7: every load traces back to a pop two cycles earlier
   a_r7_load_needs_pop: assert property (@(posedge clk) disable iff (rst)
      dac_load |-> $past(pop, 2));

   // R6: load is a single-cycle pulse
   a_r6_single_load: assert property (@(posedge clk) disable iff (rst)
      dac_load |=> !dac_load);

   // R6: data already settled when load is high
   a_r6_data_settled: assert property (@(posedge clk) disable iff (rst)
      dac_load |-> $stable(dac_data));

   // R10: status stays constant throughout a read strobe
   a_r10_status_frozen: assert property (@(posedge clk) disable iff (rst)
      (drv_en && $past(drv_en)) |-> $stable(dout));
endmodule

bind sample_streamer sample_streamer_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
   .clk(clk), .rst(rst), .level(level), .full(full), .empty(empty),
   .push_req(push_req), .pop(pop), .drv_en(drv_en), .dout(dout),
   .dac_data(dac_data), .dac_load(dac_load)
);

// File: tb/sample_streamer_test.sv
module sample_streamer_test;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH = 32;
   localparam int DIV   = 256;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic [7:0] bus_addr = 8'h00;
   logic sel_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
   logic [7:0] host_d = 8'h00;
   logic host_oe = 1'b0;
   wire  [7:0] bus_data;
   logic [7:0] dac_data;
   logic dac_chan, dac_load;

   assign bus_data = host_oe ? host_d : 8'hzz;

   sample_streamer #(.DEPTH(DEPTH), .DIV(DIV)) uut (
      .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_data(bus_data),
      .sel_n(sel_n), .rd_n(rd_n), .wr_n(wr_n),
      .dac_data(dac_data), .dac_chan(dac_chan), .dac_load(dac_load)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   int n_chk = 0, n_fail = 0, cyc = 0;
   logic done = 1'b0;
   logic [8:0] got_q[$];
   int got_cyc[$];
   logic [7:0] exp_q[$];

   always @(negedge clk) begin
      cyc <= cyc + 1;
      if (dac_load) begin
         got_q.push_back({dac_chan, dac_data});
         got_cyc.push_back(cyc);
      end
   end

   function automatic logic [7:0] stat_exp(int n);
      logic [7:0] s = 8'h00;
      s[0] = (n == 0);
      s[2] = (n >= DEPTH / 2);
      s[3] = (n == DEPTH);
      return s;
   endfunction

   task automatic check(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      got_q.delete();
      got_cyc.delete();
      exp_q.delete();
   endtask

   task automatic bus_write(logic [7:0] v);
      @(negedge clk);
      host_oe = 1'b1; host_d = v; bus_addr = 8'($urandom);
      sel_n = 1'b0; wr_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      sel_n = 1'b1; wr_n = 1'b1;
      @(negedge clk);
      host_oe = 1'b0;
   endtask

   task automatic bus_read(output logic [7:0] v);
      @(negedge clk);
      host_oe = 1'b0; sel_n = 1'b0; rd_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      v = bus_data;
      sel_n = 1'b1; rd_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic push_val(logic [7:0] v);
      bus_write(v);
      exp_q.push_back(v);
   endtask

   // compares the DAC stream with the expected queue (R5, R6, R9)
   task automatic check_stream(string tag);
      check({tag, " R5 count"}, got_q.size(), exp_q.size());
      for (int i = 0; i < got_q.size() && i < exp_q.size(); i++) begin
         check({tag, " R5 order"}, got_q[i][7:0], exp_q[i]);
         check({tag, " R9 chan"}, got_q[i][8], 0);
         if (i > 0) check({tag, " R6 spacing"}, got_cyc[i] - got_cyc[i-1], DIV);
      end
   endtask

   initial begin
      logic [7:0] s;
      void'($urandom(32'd5150));
      do_reset();
      // R8: reset state
      bus_read(s);
      check("R8 status after reset", s, 8'h01);
      check("R8 dac_load after reset", dac_load, 0);
      check("R8 dac_data after reset", dac_data, 0);

      // R1: write low without select stores nothing
      @(negedge clk); host_oe = 1'b1; host_d = 8'h5A; wr_n = 1'b0;
      repeat (2) @(negedge clk); wr_n = 1'b1; @(negedge clk); host_oe = 1'b0;
      bus_read(s);
      check("R1 no push without select", s, 8'h01);
      // R2: read without select leaves the host value on the bus
      @(negedge clk); host_oe = 1'b1; host_d = 8'h00; rd_n = 1'b0;
      repeat (2) @(negedge clk);
      check("R2 bus released without select", bus_data, 8'h00);
      rd_n = 1'b1; @(negedge clk); host_oe = 1'b0;

      // R3 half boundary, R1 single push per strobe
      for (int i = 0; i < DEPTH / 2 - 1; i++) push_val(8'($urandom));
      bus_read(s);
      check("R3 one below half", s, stat_exp(DEPTH / 2 - 1));
      push_val(8'hA7);
      bus_read(s);
      check("R1 R3 at half", s, stat_exp(DEPTH / 2));
      // R10: hold a read over the first tick
      @(negedge clk); sel_n = 1'b0; rd_n = 1'b0;
      while (cyc < DIV + 20) @(negedge clk);
      check("R10 frozen status", bus_data, stat_exp(DEPTH / 2));
      sel_n = 1'b1; rd_n = 1'b1; @(negedge clk);
      bus_read(s);
      check("R10 status after read", s, stat_exp(DEPTH / 2 - 1));
      repeat ((DEPTH / 2) * DIV + 20) @(negedge clk);
      check_stream("half");
      // R7: idle ticks while empty make no load
      repeat (3 * DIV) @(negedge clk);
      check("R7 no load while empty", got_q.size(), DEPTH / 2);
      bus_read(s);
      check("R7 empty after drain", s, 8'h01);
      push_val(8'h3C);
      repeat (DIV + 10) @(negedge clk);
      check("R7 single word after idle", got_q.size(), DEPTH / 2 + 1);
      if (got_q.size() > 0) check("R6 late word value", got_q[got_q.size()-1][7:0], 8'h3C);

      // R4: full buffer discards an extra write
      do_reset();
      for (int i = 0; i < DEPTH; i++) push_val(8'(i * 7 + 1));
      bus_read(s);
      check("R3 full status", s, stat_exp(DEPTH));
      bus_write(8'hEE);
      bus_read(s);
      check("R4 still full", s, stat_exp(DEPTH));
      repeat ((DEPTH + 2) * DIV) @(negedge clk);
      check_stream("full");

      // R8: reset mid-stream discards contents
      do_reset();
      for (int i = 0; i < 5; i++) bus_write(8'($urandom));
      do_reset();
      bus_read(s);
      check("R8 status after mid reset", s, 8'h01);
      repeat (2 * DIV) @(negedge clk);
      check("R8 no loads after reset", got_q.size(), 0);

      // random rounds
      for (int r = 0; r < 4; r++) begin
         int n;
         do_reset();
         n = 1 + int'($urandom % DEPTH);
         for (int i = 0; i < n; i++) push_val(8'($urandom));
         bus_read(s);
         check("R3 random status", s, stat_exp(n));
         repeat ((n + 1) * DIV + 20) @(negedge clk);
         check_stream("random");
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule